// File: doc/BRIEF.md
# Host-CPU Shared Interrupt Flag

This block holds one interrupt-request bit that two agents share: a local processor and an external host port. The processor raises a request toward the host by writing a control word whose flag bit is one. The host acknowledges the request by writing a control word whose flag bit is one, which clears the bit. The state of the bit is visible to both sides. A registered active-low interrupt line tells the host that a request is pending.

When both sides write a one on the same clock, the block settles it with a fixed rule instead of stalling: the set wins. The pending request is kept, so the host sees a fresh request and no event is lost. The host-side ready output is the only handshake. It drops for exactly one cycle after each accepted host write and always comes back high, so the host port can never lock up.

Top module: `irq_flag_share`

## Requirements
- R1: While reset is low at a clock edge, and after it, `flag_o` is 0, `host_irq_n` is 1 and `host_rdy` is 1.
- R2: A CPU write (`cpu_wr`=1) with bit FLAG_POS (default 2) of `cpu_wdata` set makes `flag_o` 1 from the next cycle.
- R3: An accepted host write (`host_wr`=1 while `host_rdy`=1) with bit FLAG_POS of `host_wdata` set makes `flag_o` 0 from the next cycle, unless a CPU set lands in the same cycle.
- R4: A write from either side with bit FLAG_POS at 0 leaves `flag_o` unchanged, whatever the other bits hold.
- R5: When a CPU set and an accepted host clear occur in the same cycle, `flag_o` is 1 in the next cycle.
- R6: A redundant write leaves the state as it is: a CPU set while the flag is 1 keeps it at 1, and a host clear while the flag is 0 keeps it at 0.
- R7: `host_rdy` goes to 0 for exactly the one cycle after an accepted host write and is 1 again in the cycle after that. It is never 0 on two consecutive cycles.
- R8: A host write presented while `host_rdy` is 0 is ignored and has no effect on `flag_o`.
- R9: `host_irq_n` is registered. In each cycle it equals the inverse of the value `flag_o` had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | CTRL_W | Host control word; bit FLAG_POS set means clear |
| cpu_wr | input | 1 | CPU write strobe for the control word |
| cpu_wdata | input | CTRL_W | CPU control word; bit FLAG_POS set means set |
| flag_o | output | 1 | Current state of the shared request flag |
| host_irq_n | output | 1 | Registered interrupt to the host, active low |
| host_rdy | output | 1 | Host ready; write accepted only when high |

## Verification
The bench drives a same-cycle host clear and CPU set, both while the flag is set and while it is clear. A design that gave the clear priority would drop the request, and one that froze on the collision would leave ready low. The bench issues back-to-back host writes to check that the second is ignored and that ready returns after a single cycle. A design that accepted that write would clear the flag early, and one that held ready low would hang the host. It also sends words with every bit set except the flag bit, and redundant sets and clears. These catch a decoder that looks at the wrong bit, or logic that toggles the flag instead of setting or clearing it. It tracks the one-cycle lag of the interrupt line behind the flag.

// File: rtl/irq_share_pkg.sv
// Shared types for the host/CPU interrupt flag block.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package irq_share_pkg;

    // Action that one write side requests on the shared flag in a cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } flag_act_e;

endpackage

// File: rtl/irq_wr_decode.sv
// Write decoder for one side: turns a write strobe and control word into
// a flag action. A write whose flag bit is zero yields ACT_HOLD.
// Assumes: FLAG_POS < CTRL_W; the strobe is already qualified by any
// handshake the side needs.
module irq_wr_decode
    import irq_share_pkg::*;
#(
    parameter int        CTRL_W   = 16,
    parameter int        FLAG_POS = 2,
    parameter flag_act_e HIT_ACT  = ACT_SET
) (
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output flag_act_e         act
);

    // Map a qualified write with the flag bit set onto this side's action.
    always_comb begin
        act = ACT_HOLD;
        if (wr_en && wdata[FLAG_POS]) begin
            act = HIT_ACT;
        end
    end

endmodule

// File: rtl/irq_flag_arb.sv
// Flag storage with collision rule: a CPU set beats a host clear landing
// on the same clock, so a pending request is never lost.
// Assumes: host_act only carries HOLD/CLEAR, cpu_act only HOLD/SET.
module irq_flag_arb
    import irq_share_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_act_e host_act,
    input  flag_act_e cpu_act,
    output logic      flag_q
);

    logic flag_d;

    // Resolve the two requested actions; set has priority over clear.
    always_comb begin
        flag_d = flag_q;
        if (cpu_act == ACT_SET) begin
            flag_d = 1'b1;
        end else if (host_act == ACT_CLEAR) begin
            flag_d = 1'b0;
        end
    end

    // Hold the flag; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // R2: a CPU set is visible on the next cycle
    p_cpu_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_act == ACT_SET) |=> flag_q);

    // R3: an uncontested host clear empties the flag
    p_host_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_act == ACT_CLEAR && cpu_act != ACT_SET) |=> !flag_q);

    // R4: with no action from either side the flag keeps its value
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_act == ACT_HOLD && cpu_act == ACT_HOLD) |=> $stable(flag_q));

    // R5: collision keeps the request pending
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_act == ACT_CLEAR && cpu_act == ACT_SET) |=> flag_q);

endmodule

// File: rtl/irq_rdy_gen.sv
// Host ready generator: drops ready for one cycle after each accepted host
// write and then restores it, so the host port can never stay stalled.
// Assumes: the host holds or repeats a write seen while ready is low.
module irq_rdy_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    output logic host_rdy
);

    // Ready falls after an accepted write and rises on the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdy <= 1'b1;
        end else begin
            host_rdy <= !(host_wr && host_rdy);
        end
    end

    // R7: ready is never low on two consecutive cycles
    p_rdy_recovers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdy |=> host_rdy);

    // R7: an accepted write produces the single low cycle
    p_rdy_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rdy) |=> !host_rdy);

endmodule

// File: rtl/irq_flag_share.sv
// Top: shared host/CPU interrupt-request flag. CPU writes of the flag bit
// set it, accepted host writes of the flag bit clear it, a same-cycle
// collision keeps it set, and a registered active-low line signals the host.
// Assumes: synchronous active-low reset; host writes only count while
// host_rdy is high.
module irq_flag_share
    import irq_share_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int FLAG_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              cpu_wr,
    input  logic [CTRL_W-1:0] cpu_wdata,
    output logic              flag_o,
    output logic              host_irq_n,
    output logic              host_rdy
);

    localparam int N_SIDES   = 2;
    localparam int SIDE_HOST = 0;
    localparam int SIDE_CPU  = 1;

    logic [N_SIDES-1:0] side_wr;
    logic [CTRL_W-1:0]  side_data [N_SIDES];
    flag_act_e          side_act  [N_SIDES];

    // Qualify the host strobe with ready and gather both sides into arrays.
    always_comb begin
        side_wr[SIDE_HOST]   = host_wr && host_rdy;
        side_wr[SIDE_CPU]    = cpu_wr;
        side_data[SIDE_HOST] = host_wdata;
        side_data[SIDE_CPU]  = cpu_wdata;
    end

    // One decoder per side; the host side clears, the CPU side sets.
    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        localparam flag_act_e SIDE_HIT = (g == SIDE_HOST) ? ACT_CLEAR : ACT_SET;
        irq_wr_decode #(
            .CTRL_W   (CTRL_W),
            .FLAG_POS (FLAG_POS),
            .HIT_ACT  (SIDE_HIT)
        ) u_dec (
            .wr_en (side_wr[g]),
            .wdata (side_data[g]),
            .act   (side_act[g])
        );
    end

    irq_flag_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_act (side_act[SIDE_HOST]),
        .cpu_act  (side_act[SIDE_CPU]),
        .flag_q   (flag_o)
    );

    irq_rdy_gen u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_rdy (host_rdy)
    );

    // Registered active-low interrupt toward the host, one cycle behind flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_irq_n <= 1'b1;
        end else begin
            host_irq_n <= !flag_o;
        end
    end

    // R9: interrupt line lags the flag by one cycle, inverted
    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (host_irq_n == !$past(flag_o)));

    // R8: a host write while not ready cannot clear the flag
    p_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rdy && flag_o) |=> flag_o);

    // R1: reset leaves the outputs in their idle state
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!flag_o && host_irq_n && host_rdy));

endmodule

// File: tb/irq_flag_share_test.sv
// Scoreboard bench: the driver task computes the expected outputs and
// queues them; the monitor pops and compares after each rising edge.
module irq_flag_share_test;

    localparam int CLK_PERIOD = 10;
    localparam int CTRL_W     = 16;
    localparam int FLAG_POS   = 2;
    localparam logic [CTRL_W-1:0] W_FLAG = CTRL_W'(1) << FLAG_POS;
    localparam logic [CTRL_W-1:0] W_REST = ~W_FLAG;

    typedef struct {
        logic  flag;
        logic  irq_n;
        logic  rdy;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [CTRL_W-1:0] host_wdata = '0;
    logic              cpu_wr = 1'b0;
    logic [CTRL_W-1:0] cpu_wdata = '0;
    logic              flag_o, host_irq_n, host_rdy;

    exp_t exp_q [$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;
    logic m_flag = 1'b0, m_irq_n = 1'b1, m_rdy = 1'b1;

    irq_flag_share #(.CTRL_W(CTRL_W), .FLAG_POS(FLAG_POS)) uut (
        .clk, .rst_n, .host_wr, .host_wdata, .cpu_wr, .cpu_wdata,
        .flag_o, .host_irq_n, .host_rdy
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive one cycle of writes and queue the outputs expected after the edge.
    task automatic step(input logic hw, input logic [CTRL_W-1:0] hd,
                        input logic cw, input logic [CTRL_W-1:0] cd,
                        input string tag);
        logic acc, set_hit, clr_hit;
        exp_t e;
        @(negedge clk);
        host_wr = hw; host_wdata = hd; cpu_wr = cw; cpu_wdata = cd;
        acc     = hw && m_rdy;
        set_hit = cw && cd[FLAG_POS];
        clr_hit = acc && hd[FLAG_POS];
        m_irq_n = !m_flag;
        m_flag  = set_hit ? 1'b1 : (clr_hit ? 1'b0 : m_flag);
        m_rdy   = !acc;
        e.flag = m_flag; e.irq_n = m_irq_n; e.rdy = m_rdy; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, '0, tag);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({flag_o, host_irq_n, host_rdy} !== {e.flag, e.irq_n, e.rdy}) begin
                n_fails++;
                $display("FAIL %s: flag/irq_n/rdy got %b%b%b expected %b%b%b",
                         e.tag, flag_o, host_irq_n, host_rdy,
                         e.flag, e.irq_n, e.rdy);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle values while reset is held
        n_checks++;
        if ({flag_o, host_irq_n, host_rdy} !== 3'b011) begin
            n_fails++;
            $display("FAIL R1: flag/irq_n/rdy got %b%b%b expected 011",
                     flag_o, host_irq_n, host_rdy);
        end
        rst_n = 1'b1;
        idle("R1");
        // R4: CPU word without the flag bit
        step(1'b0, '0, 1'b1, W_REST, "R4");
        idle("R4");
        // R2: CPU set with extra bits
        step(1'b0, '0, 1'b1, W_FLAG | 16'h8001, "R2");
        idle("R2");
        // R6: redundant CPU set
        step(1'b0, '0, 1'b1, W_FLAG, "R6");
        idle("R6");
        // R4: host word without the flag bit (accepted, no effect)
        step(1'b1, W_REST, 1'b0, '0, "R4");
        // R8: back-to-back host clear while ready is low is ignored
        step(1'b1, W_FLAG, 1'b0, '0, "R8");
        idle("R8");
        // R3: accepted host clear
        step(1'b1, W_FLAG, 1'b0, '0, "R3");
        idle("R7");
        // R6: redundant host clear
        step(1'b1, W_FLAG | W_REST, 1'b0, '0, "R6");
        idle("R6");
        // R5: collision while flag is clear
        step(1'b1, W_FLAG, 1'b1, W_FLAG, "R5");
        idle("R5");
        // R5: collision while flag is set
        step(1'b1, W_FLAG, 1'b1, W_FLAG, "R5");
        idle("R7");
        // R7: continuous host strobe alternates ready
        for (int i = 0; i < 4; i++) step(1'b1, '0, 1'b0, '0, "R7");
        // R3 then R9: clear and watch the interrupt line follow
        step(1'b1, W_FLAG, 1'b0, '0, "R3");
        idle("R9");
        idle("R9");
        step(1'b0, '0, 1'b1, W_FLAG, "R9");
        idle("R9");
        idle("R9");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule